// File: doc/BRIEF.md
# Per-Cycle Processor Clock Switcher

This block decides, bus cycle by bus cycle, whether the processor is clocked from a fast free-running oscillator or from the slower motherboard system clock (about 7 MHz). Accesses to memory on the processor board run at the full fast rate. Accesses aimed at motherboard chip memory or custom-chip registers must run in step with the system clock. The decision is taken when the processor asserts its address strobe, using a decoded flag that marks the access as remote.

All logic runs in the fast clock domain. The system clock is treated as an asynchronous input and passed through a synchronizer, and its rising edges are detected. Two outputs drive the processor clock path. A run enable gates the clock and holds the processor clock at its current level while it is low. A select chooses between the fast clock and the system clock. When an access goes to the slow side, the enable is dropped at once, and the select changes to the system clock only on a detected rising edge of that clock, so the processor never receives the system clock in the wrong phase. When the remote cycle ends, marked by the address strobe negating, the clock is frozen for one cycle and then the fast clock resumes.

Top module: `cpu_clk_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, `cpuClkSys` is 1 (system clock selected) and `cpuClkRun` is 1.
- R2: In fast mode (`cpuClkRun`=1, `cpuClkSys`=0), a bus cycle whose strobe assertion sees `remoteHit`=0 leaves both outputs unchanged for the whole cycle.
- R3: In fast mode, a strobe assertion (`busStrobeN` going from 1 to 0) with `remoteHit`=1 makes `cpuClkRun` 0 from the next clock on, with `cpuClkSys` still 0.
- R4: While frozen on the way to the system clock, the outputs stay at `cpuClkRun`=0, `cpuClkSys`=0 until a rising edge of `sysClk` is detected. A system clock that is already high, or that falls, does not release the freeze.
- R5: After `sysClk` rises, the outputs change to `cpuClkRun`=1, `cpuClkSys`=1 exactly SYNC_STAGES+1 fast clocks later, and do not change before that.
- R6: `remoteHit` is sampled only on the fast clock at which the strobe assertion is first seen. Changes to it at any other time have no effect on the outputs.
- R7: When `busStrobeN` rises at the end of a remote cycle on the system clock, the next clock gives `cpuClkRun`=0, `cpuClkSys`=1, and the clock after that gives fast mode (`cpuClkRun`=1, `cpuClkSys`=0).
- R8: On the system clock (for example after reset), a strobe assertion with `remoteHit`=0 gives one clock of `cpuClkRun`=0, `cpuClkSys`=1, and then fast mode.
- R9: `cpuClkSys` changes only on a clock that follows a cycle in which `cpuClkRun` was 0. The select never changes while the clock runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running clock; all logic runs in this domain |
| rstN | input | 1 | Synchronous active-low reset |
| sysClk | input | 1 | Motherboard system clock, asynchronous, oversampled |
| busStrobeN | input | 1 | Processor address strobe, active low, synchronous to clk |
| remoteHit | input | 1 | Decoded flag: the current address targets motherboard resources |
| cpuClkRun | output | 1 | Clock enable; 0 holds the processor clock at its current level |
| cpuClkSys | output | 1 | Clock select; 1 = system clock, 0 = fast clock |

## Verification
The checker assumes that the address strobe and the remote flag are synchronous to the fast clock and that the remote flag is valid in the cycle where the strobe is first seen asserted. The bench drives both only on falling edges of the fast clock, which satisfies these assumptions. The system clock is the one input the properties treat as arbitrary. The bench moves it by hand at falling fast-clock edges and holds each level for several fast cycles, so that the exact number of synchronizer stages can be counted for the hand-over. The checker does not model the synchronizer. It checks the entry and exit of the freezes and the rule that the select is stable while the clock runs.

// File: rtl/cpu_clk_switch_pkg.sv
package cpu_clk_switch_pkg;

  typedef enum logic [1:0] {
    FAST_RUN  = 2'd0,
    HOLD_SYS  = 2'd1,
    SYS_RUN   = 2'd2,
    HOLD_FAST = 2'd3
  } clkModeT;

  typedef struct packed {
    logic latchRemote;
    logic clkRun;
    logic useSys;
  } ctrlStrobeT;

  typedef struct packed {
    logic strobeFall;
    logic strobeRise;
    logic sysRise;
    logic cycleRemote;
  } dpStatusT;

endpackage

// File: rtl/cpu_clk_switch_dp.sv
module cpu_clk_switch_dp
  import cpu_clk_switch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysClk,
  input  logic       busStrobeN,
  input  logic       remoteHit,
  input  ctrlStrobeT ctrl,
  output dpStatusT   status,
  output logic       cpuClkRun,
  output logic       cpuClkSys
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          syncPrev;
  logic          strobePrevN;
  logic          remoteLatched;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= sysClk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev      <= 1'b0;
      strobePrevN   <= 1'b1;
      remoteLatched <= 1'b1;
    end else begin
      syncPrev    <= syncChain[LAST];
      strobePrevN <= busStrobeN;
      if (ctrl.latchRemote) remoteLatched <= remoteHit;
    end
  end

  always_comb begin
    status.strobeFall  = strobePrevN & ~busStrobeN;
    status.strobeRise  = ~strobePrevN & busStrobeN;
    status.sysRise     = syncChain[LAST] & ~syncPrev;
    status.cycleRemote = remoteLatched;
  end

  assign cpuClkRun = ctrl.clkRun;
  assign cpuClkSys = ctrl.useSys;

endmodule

// File: rtl/cpu_clk_switch_ctrl.sv
module cpu_clk_switch_ctrl
  import cpu_clk_switch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       remoteHit,
  input  dpStatusT   status,
  output ctrlStrobeT ctrl
);

  clkModeT mode, modeNext;

  always_ff @(posedge clk) begin
    if (!rstN) mode <= SYS_RUN;
    else       mode <= modeNext;
  end

  always_comb begin
    modeNext = mode;
    unique case (mode)
      FAST_RUN:  if (status.strobeFall && remoteHit) modeNext = HOLD_SYS;
      HOLD_SYS:  if (status.sysRise) modeNext = SYS_RUN;
      SYS_RUN: begin
        if (status.strobeFall && !remoteHit)                modeNext = HOLD_FAST;
        else if (status.strobeRise && status.cycleRemote)   modeNext = HOLD_FAST;
      end
      HOLD_FAST: modeNext = FAST_RUN;
      default:   modeNext = SYS_RUN;
    endcase
  end

  always_comb begin
    ctrl.latchRemote = status.strobeFall;
    ctrl.clkRun      = (mode == FAST_RUN) || (mode == SYS_RUN);
    ctrl.useSys      = (mode == SYS_RUN) || (mode == HOLD_FAST);
  end

endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import cpu_clk_switch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sysClk,
  input  logic busStrobeN,
  input  logic remoteHit,
  output logic cpuClkRun,
  output logic cpuClkSys
);

  ctrlStrobeT ctrl;
  dpStatusT   status;

  cpu_clk_switch_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .remoteHit (remoteHit),
    .status    (status),
    .ctrl      (ctrl)
  );

  cpu_clk_switch_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sysClk     (sysClk),
    .busStrobeN (busStrobeN),
    .remoteHit  (remoteHit),
    .ctrl       (ctrl),
    .status     (status),
    .cpuClkRun  (cpuClkRun),
    .cpuClkSys  (cpuClkSys)
  );

endmodule

// File: rtl/cpu_clk_switch_chk.sv
module cpu_clk_switch_chk (
  input logic clk,
  input logic rstN,
  input logic busStrobeN,
  input logic remoteHit,
  input logic cpuClkRun,
  input logic cpuClkSys
);

  logic seenStrobeN;

  always_ff @(posedge clk) begin
    if (!rstN) seenStrobeN <= 1'b1;
    else       seenStrobeN <= busStrobeN;
  end

  // R2
  fast_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkRun && !cpuClkSys && !(seenStrobeN && !busStrobeN && remoteHit))
      |=> (cpuClkRun && !cpuClkSys));

  // R3
  remote_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkRun && !cpuClkSys && seenStrobeN && !busStrobeN && remoteHit)
      |=> (!cpuClkRun && !cpuClkSys));

  // R7
  end_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkRun && cpuClkSys && !seenStrobeN && busStrobeN)
      |=> !cpuClkRun);

  // R8
  resume_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkRun && cpuClkSys) |=> (cpuClkRun && !cpuClkSys));

  // R9
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cpuClkSys) |-> !$past(cpuClkRun));

endmodule

bind cpu_clk_switch cpu_clk_switch_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busStrobeN (busStrobeN),
  .remoteHit  (remoteHit),
  .cpuClkRun  (cpuClkRun),
  .cpuClkSys  (cpuClkSys)
);

// File: tb/cpu_clk_switch_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_switch_tb_top;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysClk = 1'b0;
  logic busStrobeN = 1'b1;
  logic remoteHit = 1'b0;
  logic cpuClkRun, cpuClkSys;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cpu_clk_switch #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .sysClk(sysClk), .busStrobeN(busStrobeN),
    .remoteHit(remoteHit), .cpuClkRun(cpuClkRun), .cpuClkSys(cpuClkSys)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic expRun, logic expSys);
    checks++;
    if (cpuClkRun !== expRun || cpuClkSys !== expSys) begin
      fails++;
      $display("FAIL %s: run/sys actual %b/%b expected %b/%b",
               req, cpuClkRun, cpuClkSys, expRun, expSys);
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0; busStrobeN = 1'b1; remoteHit = 1'b0; sysClk = 1'b0;
    tick(4);
    expect_out("R1", 1'b1, 1'b1);
    rstN = 1'b1;
    tick(1);
    expect_out("R1", 1'b1, 1'b1);
  endtask

  // R8: local cycle straight out of reset
  task automatic t_boot_local();
    busStrobeN = 1'b0; remoteHit = 1'b0;
    tick(1); expect_out("R8", 1'b0, 1'b1);
    tick(1); expect_out("R8", 1'b1, 1'b0);
    busStrobeN = 1'b1;
    tick(2); expect_out("R2", 1'b1, 1'b0);
  endtask

  // R2, R6: local cycle stays fast even if remoteHit moves later
  task automatic t_local();
    busStrobeN = 1'b0; remoteHit = 1'b0;
    tick(1); expect_out("R2", 1'b1, 1'b0);
    remoteHit = 1'b1;
    tick(3); expect_out("R6", 1'b1, 1'b0);
    busStrobeN = 1'b1;
    tick(2); expect_out("R2", 1'b1, 1'b0);
    remoteHit = 1'b0;
  endtask

  // R3, R4, R5, R6, R7: remote cycle from fast mode, sysClk low at start
  task automatic t_remote_low();
    sysClk = 1'b0; tick(4);
    busStrobeN = 1'b0; remoteHit = 1'b1;
    tick(1); expect_out("R3", 1'b0, 1'b0);
    remoteHit = 1'b0;
    tick(5); expect_out("R4", 1'b0, 1'b0);
    sysClk = 1'b1;
    tick(SYNC); expect_out("R5", 1'b0, 1'b0);
    tick(1); expect_out("R5", 1'b1, 1'b1);
    tick(3); sysClk = 1'b0; remoteHit = 1'b1;
    tick(4); expect_out("R6", 1'b1, 1'b1);
    remoteHit = 1'b0;
    busStrobeN = 1'b1;
    tick(1); expect_out("R7", 1'b0, 1'b1);
    tick(1); expect_out("R7", 1'b1, 1'b0);
  endtask

  // R4: sysClk already high then falling does not release the freeze
  task automatic t_remote_high();
    sysClk = 1'b1; tick(5);
    busStrobeN = 1'b0; remoteHit = 1'b1;
    tick(1); expect_out("R3", 1'b0, 1'b0);
    tick(6); expect_out("R4", 1'b0, 1'b0);
    sysClk = 1'b0;
    tick(6); expect_out("R4", 1'b0, 1'b0);
    sysClk = 1'b1;
    tick(SYNC); expect_out("R5", 1'b0, 1'b0);
    tick(1); expect_out("R5", 1'b1, 1'b1);
    busStrobeN = 1'b1; remoteHit = 1'b0;
    tick(1); expect_out("R7", 1'b0, 1'b1);
    tick(1); expect_out("R7", 1'b1, 1'b0);
    sysClk = 1'b0;
  endtask

  // R1, R7: remote cycle right after reset stays on system clock
  task automatic t_boot_remote();
    do_reset();
    busStrobeN = 1'b0; remoteHit = 1'b1;
    tick(3); expect_out("R6", 1'b1, 1'b1);
    busStrobeN = 1'b1; remoteHit = 1'b0;
    tick(1); expect_out("R7", 1'b0, 1'b1);
    tick(1); expect_out("R7", 1'b1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_boot_local();
    t_local();
    t_remote_low();
    t_remote_high();
    t_local();
    t_boot_remote();
    t_remote_low();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule